// File: doc/BRIEF.md
# Mains-Locked Pulse Trigger Generator

This block produces the repeating set of trigger lines that gate pulsed high-power equipment and the sampling chain. Each repetition is anchored to a single-cycle internal master event. Master events are locked to a 50 Hz line reference in one of two ways. In the first, the block fires on every K-th rising edge of that reference. In the second, it measures the time between line edges and splits each line period into M evenly spaced events. Every line edge starts the spacing again, so timing drift cannot build up across periods.

Each trigger output has its own delay and width, counted in clock cycles from the master event. Devices with different latencies can therefore be started at different times. A data-ready pulse follows each burst of triggers so that readout software can collect the acquired samples before the next burst. An inhibit input blanks the outputs that drive the RF chain.

Top module: `trig_sync_gen`

## Requirements
- R1: While `rst_n` is low, `trig_o`, `master_o` and `data_rdy_o` are all low.
- R2: With `rate_mode_i` = 0 (divide), `master_o` pulses for one cycle on the first sampled rising edge of `mains_ref` after reset and then on every K-th rising edge. It is high in the cycle after the clock edge that first samples `mains_ref` high. K is `rate_ratio_i` as sampled at each line edge.
- R3: With `rate_mode_i` = 1 (multiply), every line rising edge yields a master event. Once two edges have given a measured period P, master events also follow at ceil(k·P/M) cycles after each edge, for k = 1 to M−1.
- R4: A ratio of 0 is treated as 1. A ratio above the mode limit is treated as the limit: 8 in multiply mode, 50 in divide mode.
- R5: For channel i, with delay D and width W taken from slice i of `dly_i`/`wid_i` (bits i·CNT_W upward), `trig_o[i]` rises D cycles after `master_o` and stays high for exactly W cycles. W = 0 produces no pulse.
- R6: Delay and width are captured only at a master event, so changing them during a pulse has no effect on that pulse. Mode and ratio are captured only at line edges.
- R7: A master event that arrives while a channel is still in its delay or high phase is ignored by that channel. The other channels still respond to it.
- R8: While `inhibit_i` is high, the outputs selected by `RF_MASK` (default: channels 0 and 1) are held low. Channel 2 is unaffected.
- R9: `data_rdy_o` pulses for one cycle, one cycle after the last channel returns to idle following a master event. If every width is zero, it pulses one cycle after the master event. Master events that arrive before that point merge into a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mains_ref | input | 1 | Line reference, synchronous to clk; rising edge is the event |
| rate_mode_i | input | 1 | 0 = divide by K, 1 = multiply by M |
| rate_ratio_i | input | RATIO_W | K or M |
| dly_i | input | N_TRIG*CNT_W | Per-channel delay in cycles |
| wid_i | input | N_TRIG*CNT_W | Per-channel width in cycles |
| inhibit_i | input | 1 | Blanks the RF-related outputs |
| trig_o | output | N_TRIG | Trigger lines |
| master_o | output | 1 | Master event pulse |
| data_rdy_o | output | 1 | Per-burst new-data event |

## Verification
The bench targets the following corner cases:

- **Uneven period split.** A line period that M does not divide evenly (203 cycles into three) is used. A design that truncates instead of rounding up would place the slots one cycle early.
- **Out-of-range ratios.** Ratios of zero and ratios above the limits are applied. A design that omits clamping would stall, or would produce 20 or 63 slots or divisions instead of 8 or 50.
- **Changes mid-burst.** The delay, width and ratio are changed while a burst is in progress. A design with no capture stage would stretch or cut the running pulse.
- **Overlapping bursts.** A delay longer than the period is used. A design that restarts a channel on each master event would lose the first pulse, and a design with per-event ready pulses would emit two ready pulses where one is required.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic {
      RATE_DIV = 1'b0,
      RATE_MUL = 1'b1
   } rate_mode_e;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_DELAY = 2'd1,
      CH_HIGH  = 2'd2
   } ch_state_e;
endpackage

// File: rtl/trig_rate.sv
module trig_rate
   import trig_pkg::*;
#(
   parameter int PER_W   = 24,
   parameter int RATIO_W = 6,
   parameter int MUL_MAX = 8,
   parameter int DIV_MAX = 50
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mains_ref,
   input  logic               mode_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               fire_o,
   output logic               master_o
);
   localparam int ACC_W = PER_W + 1;
   localparam logic [PER_W-1:0] PER_SAT = '1;

   if (MUL_MAX < 1 || DIV_MAX < 1) begin : g_bad_lim
      $error("ratio limits must be at least 1");
   end
   if (MUL_MAX >= 2**RATIO_W || DIV_MAX >= 2**RATIO_W) begin : g_bad_w
      $error("RATIO_W too narrow for ratio limits");
   end

   function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] v,
                                                       input int hi);
      if (v == '0) return RATIO_W'(1);
      if (v > RATIO_W'(hi)) return RATIO_W'(hi);
      return v;
   endfunction

   logic               mains_d;
   logic               rise;
   logic               seen_q, valid_q;
   logic [PER_W-1:0]   per_cnt_q, period_q;
   logic [ACC_W-1:0]   acc_q, acc_nxt;
   logic [RATIO_W-1:0] slot_q, mul_q, div_cnt_q;
   logic [RATIO_W-1:0] mul_in, div_in;
   rate_mode_e         mode_q, mode_in;
   logic               slot_run, slot_go;

   assign rise     = mains_ref & ~mains_d;
   assign mode_in  = rate_mode_e'(mode_i);
   assign mul_in   = clamp_ratio(ratio_i, MUL_MAX);
   assign div_in   = clamp_ratio(ratio_i, DIV_MAX);
   assign acc_nxt  = acc_q + ACC_W'(mul_q);
   assign slot_run = (mode_q == RATE_MUL) && valid_q && (slot_q < mul_q - RATIO_W'(1));
   assign slot_go  = slot_run && !rise && (acc_nxt >= {1'b0, period_q});
   assign fire_o   = (rise && (mode_in == RATE_MUL || div_cnt_q == '0)) || slot_go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mains_d   <= 1'b0;
         master_o  <= 1'b0;
         seen_q    <= 1'b0;
         valid_q   <= 1'b0;
         per_cnt_q <= '0;
         period_q  <= '0;
         acc_q     <= '0;
         slot_q    <= '0;
         mul_q     <= RATIO_W'(1);
         div_cnt_q <= '0;
         mode_q    <= RATE_DIV;
      end else begin
         mains_d  <= mains_ref;
         master_o <= fire_o;
         if (rise) per_cnt_q <= PER_W'(1);
         else if (per_cnt_q != PER_SAT) per_cnt_q <= per_cnt_q + PER_W'(1);
         if (rise) begin
            seen_q  <= 1'b1;
            valid_q <= seen_q;
            if (seen_q) period_q <= per_cnt_q;
            mode_q  <= mode_in;
            mul_q   <= mul_in;
            acc_q   <= '0;
            slot_q  <= '0;
            if (mode_in == RATE_MUL || div_cnt_q >= div_in - RATIO_W'(1)) div_cnt_q <= '0;
            else div_cnt_q <= div_cnt_q + RATIO_W'(1);
         end else if (slot_run) begin
            if (slot_go) begin
               acc_q  <= acc_nxt - {1'b0, period_q};
               slot_q <= slot_q + RATIO_W'(1);
            end else begin
               acc_q  <= acc_nxt;
            end
         end
      end
   end

   // R3: every line edge in multiply mode yields a master event
   a_r3_edge_master: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && mode_i) |=> master_o);

   // R2: between line edges, divide mode stays silent
   a_r2_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise && mode_q == RATE_DIV) |=> !master_o);
endmodule

// File: rtl/trig_chan.sv
module trig_chan
   import trig_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [CNT_W-1:0] dly_i,
   input  logic [CNT_W-1:0] wid_i,
   output logic             busy_o,
   output logic             trig_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   ch_state_e        state_q;
   logic [CNT_W-1:0] cnt_q, wid_q;

   assign busy_o = (state_q != CH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         cnt_q   <= '0;
         wid_q   <= '0;
         trig_o  <= 1'b0;
      end else begin
         unique case (state_q)
            CH_IDLE: begin
               if (fire_i && wid_i != '0) begin
                  wid_q <= wid_i;
                  if (dly_i == '0) begin
                     state_q <= CH_HIGH;
                     cnt_q   <= wid_i - CNT_W'(1);
                     trig_o  <= 1'b1;
                  end else begin
                     state_q <= CH_DELAY;
                     cnt_q   <= dly_i - CNT_W'(1);
                  end
               end
            end
            CH_DELAY: begin
               if (cnt_q == '0) begin
                  state_q <= CH_HIGH;
                  cnt_q   <= wid_q - CNT_W'(1);
                  trig_o  <= 1'b1;
               end else begin
                  cnt_q   <= cnt_q - CNT_W'(1);
               end
            end
            CH_HIGH: begin
               if (cnt_q == '0) begin
                  state_q <= CH_IDLE;
                  trig_o  <= 1'b0;
               end else begin
                  cnt_q   <= cnt_q - CNT_W'(1);
               end
            end
            default: state_q <= CH_IDLE;
         endcase
      end
   end

   // R5: a pulse is held until its width is used up
   a_r5_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_HIGH && cnt_q != '0) |=> trig_o);

   // R5: zero width from idle produces no pulse
   a_r5_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && state_q == CH_IDLE && wid_i == '0) |=> !trig_o);

   // R7: a master event during the delay phase leaves the captured width alone
   a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && state_q == CH_DELAY) |=> $stable(wid_q));
endmodule

// File: rtl/trig_sync_gen.sv
module trig_sync_gen
   import trig_pkg::*;
#(
   parameter int                N_TRIG  = 3,
   parameter int                CNT_W   = 20,
   parameter int                PER_W   = 24,
   parameter int                RATIO_W = 6,
   parameter int                MUL_MAX = 8,
   parameter int                DIV_MAX = 50,
   parameter logic [N_TRIG-1:0] RF_MASK = N_TRIG'(3)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mains_ref,
   input  logic                      rate_mode_i,
   input  logic [RATIO_W-1:0]        rate_ratio_i,
   input  logic [N_TRIG*CNT_W-1:0]   dly_i,
   input  logic [N_TRIG*CNT_W-1:0]   wid_i,
   input  logic                      inhibit_i,
   output logic [N_TRIG-1:0]         trig_o,
   output logic                      master_o,
   output logic                      data_rdy_o
);
   if (N_TRIG < 1) begin : g_bad_n
      $error("N_TRIG must be at least 1");
   end

   logic              fire;
   logic [N_TRIG-1:0] busy, raw;
   logic              pend_q, all_idle;

   trig_rate #(
      .PER_W  (PER_W),
      .RATIO_W(RATIO_W),
      .MUL_MAX(MUL_MAX),
      .DIV_MAX(DIV_MAX)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .mains_ref(mains_ref),
      .mode_i   (rate_mode_i),
      .ratio_i  (rate_ratio_i),
      .fire_o   (fire),
      .master_o (master_o)
   );

   for (genvar g = 0; g < N_TRIG; g++) begin : g_ch
      trig_chan #(.CNT_W(CNT_W)) u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .fire_i(fire),
         .dly_i (dly_i[g*CNT_W +: CNT_W]),
         .wid_i (wid_i[g*CNT_W +: CNT_W]),
         .busy_o(busy[g]),
         .trig_o(raw[g])
      );
      if (RF_MASK[g]) begin : g_rf
         assign trig_o[g] = raw[g] & ~inhibit_i;
      end else begin : g_plain
         assign trig_o[g] = raw[g];
      end
   end

   assign all_idle = ~|busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         data_rdy_o <= 1'b0;
      end else begin
         data_rdy_o <= pend_q & all_idle;
         pend_q     <= fire | (pend_q & ~all_idle);
      end
   end

   // R9: the ready pulse only follows a master event that is still pending
   a_r9_rdy_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q) |=> !data_rdy_o);
endmodule

// File: tb/test_trig_sync_gen.sv
module test_trig_sync_gen;
   localparam int CLK_PERIOD = 10;
   localparam int N = 3;
   localparam int CW = 20;
   localparam int RW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mains_ref = 1'b0;
   logic          rate_mode_i = 1'b0;
   logic [RW-1:0] rate_ratio_i = RW'(1);
   logic [N*CW-1:0] dly_i = '0;
   logic [N*CW-1:0] wid_i = '0;
   logic          inhibit_i = 1'b0;
   logic [N-1:0]  trig_o;
   logic          master_o, data_rdy_o;

   trig_sync_gen i_trig_sync_gen (
      .clk(clk), .rst_n(rst_n), .mains_ref(mains_ref),
      .rate_mode_i(rate_mode_i), .rate_ratio_i(rate_ratio_i),
      .dly_i(dly_i), .wid_i(wid_i), .inhibit_i(inhibit_i),
      .trig_o(trig_o), .master_o(master_o), .data_rdy_o(data_rdy_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {int ch; int rise; int wid;} tev_t;
   tev_t trig_q[$];
   int   master_q[$];
   int   rdy_q[$];

   int cyc = 0, checks = 0, errors = 0;
   int busy_until[N];
   int cur_d[N], cur_w[N];
   bit cur_inh = 0;
   int last_rdy = -1, seen = 0, bdiv = 0, last_e = 0;
   bit b_mode = 0;
   int b_ratio = 1;
   string tag_m = "R2", tag_t = "R5";
   bit done = 0;

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int clampv(input int v, input int hi);
      if (v == 0) return 1;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic void expect_master(input int m);
      int mx;
      master_q.push_back(m);
      for (int c = 0; c < N; c++) begin
         if (m > busy_until[c] && cur_w[c] > 0) begin
            busy_until[c] = m + cur_d[c] + cur_w[c];
            if (!(cur_inh && c < 2)) trig_q.push_back('{c, m + cur_d[c], cur_w[c]});
         end
      end
      mx = m + 1;
      for (int c = 0; c < N; c++) if (busy_until[c] + 1 > mx) mx = busy_until[c] + 1;
      if (rdy_q.size() > 0 && m < last_rdy) void'(rdy_q.pop_back());
      rdy_q.push_back(mx);
      last_rdy = mx;
   endfunction

   function automatic void model_edge(input int e);
      int k;
      if (!b_mode) begin
         k = clampv(b_ratio, 50);
         if (bdiv == 0) expect_master(e);
         bdiv = (bdiv >= k - 1) ? 0 : bdiv + 1;
      end else begin
         k = clampv(b_ratio, 8);
         bdiv = 0;
         expect_master(e);
         if (seen >= 1)
            for (int s = 1; s < k; s++) expect_master(e + (s * (e - last_e) + k - 1) / k);
      end
      seen++;
      last_e = e;
   endfunction

   task automatic set_rate(input bit md, input int r);
      rate_mode_i = md; rate_ratio_i = RW'(r);
      b_mode = md; b_ratio = r;
   endtask

   task automatic set_cfg(input int d0, input int d1, input int d2,
                          input int w0, input int w1, input int w2);
      dly_i = {CW'(d2), CW'(d1), CW'(d0)};
      wid_i = {CW'(w2), CW'(w1), CW'(w0)};
      cur_d[0] = d0; cur_d[1] = d1; cur_d[2] = d2;
      cur_w[0] = w0; cur_w[1] = w1; cur_w[2] = w2;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rise_edge();
      @(negedge clk);
      mains_ref = 1'b1;
      model_edge(cyc + 1);
      idle(2);
      mains_ref = 1'b0;
   endtask

   task automatic train(input int n, input int per);
      for (int j = 0; j < n; j++) begin
         rise_edge();
         idle(per - 3);
      end
   endtask

   task automatic flush(input string tag);
      idle(300);
      chk(master_q.size() == 0, tag, "missing master events", master_q.size(), 0);
      chk(trig_q.size() == 0, tag, "missing trigger pulses", trig_q.size(), 0);
      chk(rdy_q.size() == 0, "R9", "missing ready pulses", rdy_q.size(), 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      master_q.delete(); trig_q.delete(); rdy_q.delete();
      for (int c = 0; c < N; c++) busy_until[c] = -1;
      last_rdy = -1; seen = 0; bdiv = 0; last_e = 0; cur_inh = 0;
      idle(3);
      chk(trig_o == '0, "R1", "trig in reset", int'(trig_o), 0);
      chk(master_o == 1'b0, "R1", "master in reset", int'(master_o), 0);
      chk(data_rdy_o == 1'b0, "R1", "ready in reset", int'(data_rdy_o), 0);
      rst_n = 1'b1;
   endtask

   // monitor: pops expectations as the design produces results
   bit [N-1:0] prev = '0;
   int rise_at[N];
   always @(negedge clk) begin
      int e;
      int idx;
      if (!rst_n) begin
         prev = '0;
      end else if (!done) begin
         if (master_o) begin
            if (master_q.size() == 0) chk(0, tag_m, "unexpected master", cyc, -1);
            else begin
               e = master_q.pop_front();
               chk(cyc == e, tag_m, "master cycle", cyc, e);
            end
         end
         for (int c = 0; c < N; c++) begin
            if (trig_o[c] && !prev[c]) rise_at[c] = cyc;
            if (!trig_o[c] && prev[c]) begin
               idx = -1;
               for (int i = 0; i < trig_q.size(); i++)
                  if (idx < 0 && trig_q[i].ch == c) idx = i;
               if (idx < 0) chk(0, tag_t, "unexpected pulse", rise_at[c], -1);
               else begin
                  chk(rise_at[c] == trig_q[idx].rise, tag_t, "pulse start",
                      rise_at[c], trig_q[idx].rise);
                  chk(cyc - rise_at[c] == trig_q[idx].wid, tag_t, "pulse width",
                      cyc - rise_at[c], trig_q[idx].wid);
                  trig_q.delete(idx);
               end
            end
            prev[c] = trig_o[c];
         end
         if (data_rdy_o) begin
            if (rdy_q.size() == 0) chk(0, "R9", "unexpected ready", cyc, -1);
            else begin
               e = rdy_q.pop_front();
               chk(cyc == e, "R9", "ready cycle", cyc, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d expected end before %0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      set_cfg(0, 0, 0, 0, 0, 0);
      set_rate(0, 1);
      // R1 / R2: divide by one and by three
      do_reset();
      tag_m = "R2";
      train(4, 100);
      flush("R2");
      do_reset();
      set_rate(0, 3);
      train(7, 100);
      flush("R2");
      // R3: multiply, even and uneven split
      do_reset();
      tag_m = "R3";
      set_rate(1, 4);
      train(3, 200);
      flush("R3");
      do_reset();
      set_rate(1, 3);
      train(3, 203);
      flush("R3");
      // R4: clamping of ratios
      do_reset();
      tag_m = "R4";
      set_rate(1, 20);
      train(3, 80);
      flush("R4");
      do_reset();
      set_rate(0, 0);
      train(3, 50);
      flush("R4");
      do_reset();
      set_rate(0, 63);
      train(51, 40);
      flush("R4");
      // R5: delays and widths, including zero width
      do_reset();
      tag_m = "R5"; tag_t = "R5";
      set_rate(0, 1);
      set_cfg(0, 7, 30, 1, 4, 12);
      train(2, 100);
      set_cfg(3, 0, 0, 5, 0, 2);
      train(2, 100);
      flush("R5");
      // R6: changes mid-burst wait for the next capture point
      do_reset();
      tag_m = "R6"; tag_t = "R6";
      set_cfg(5, 10, 15, 8, 8, 8);
      rise_edge();
      dly_i = {3{CW'(40)}};
      wid_i = {3{CW'(2)}};
      idle(97);
      set_cfg(40, 40, 40, 2, 2, 2);
      rise_edge();
      idle(97);
      flush("R6");
      do_reset();
      set_cfg(0, 0, 0, 0, 0, 0);
      set_rate(1, 4);
      rise_edge(); idle(197);
      rise_edge(); idle(10);
      rate_ratio_i = RW'(2);
      idle(187);
      b_ratio = 2;
      rise_edge(); idle(197);
      flush("R6");
      // R7: master during a long delay is ignored by that channel
      do_reset();
      tag_m = "R7"; tag_t = "R7";
      set_rate(0, 1);
      set_cfg(250, 5, 0, 10, 5, 3);
      train(2, 200);
      flush("R7");
      // R8: inhibit blanks only the RF outputs
      do_reset();
      tag_m = "R8"; tag_t = "R8";
      set_cfg(2, 4, 6, 3, 3, 3);
      inhibit_i = 1'b1;
      cur_inh = 1;
      rise_edge();
      idle(3);
      chk(trig_o[1:0] == 2'b00, "R8", "inhibited outputs", int'(trig_o[1:0]), 0);
      idle(94);
      inhibit_i = 1'b0;
      cur_inh = 0;
      rise_edge();
      idle(97);
      flush("R8");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule